// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs a single processor bus cycle, one T-state per clock, on a bus where the low address byte and the data byte share the same pins. A request names one of five cycle kinds: opcode fetch, memory read, memory write, I/O read or I/O write. It also carries a 16-bit address and, for writes, a data byte. The sequencer then drives the latch-enable pulse, the active-low read and write strobes, the I/O-or-memory select, two status bits, the upper address byte and the shared byte lane.

The shared lane is modelled as separate out, in and output-enable signals, which the pad ring joins into one tri-state pin. The same is done for the upper address byte. A READY input stretches the cycle by adding wait T-states. When the cycle ends, a one-clock done pulse appears, and for read-type cycles the byte taken from the bus is shown on the read-data output. The caller issues a request while the sequencer is idle and waits for done before it issues the next one.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset and while idle, the outputs are as follows: ale=0, rd_n=1, wr_n=1, status {s1,s0}=00, io_m=0, ad_oe=0, addr_hi_oe=0 and done=0.
- R2: A request starts a cycle only when req_valid is high while the sequencer is idle and req_code is one of 0 (opcode fetch), 1 (memory read), 2 (memory write), 3 (I/O read) or 4 (I/O write). Codes 5 to 7 are ignored, and so is any request made while a cycle is in progress. An ignored request produces no ale pulse.
- R3: T1 is the clock after the request is accepted. In T1, ale is high for exactly one clock, ad_out carries address bits [7:0] with ad_oe=1, and addr_hi carries address bits [15:8] with addr_hi_oe=1. addr_hi_oe stays high until the end of T3.
- R4: During every T-state of a cycle, {s1,s0} is 11 for an opcode fetch, 10 for a memory or I/O read, and 01 for a memory or I/O write. It returns to 00 when the sequencer goes idle.
- R5: During a cycle, io_m is 1 for codes 3 and 4 and 0 for codes 0 to 2.
- R6: In read-type cycles (codes 0, 1 and 3), rd_n is low in T2, in every wait state and in T3. ad_oe is 0 whenever rd_n is low.
- R7: In write cycles (codes 2 and 4), wr_n is low in T2, in every wait state and in T3, and ad_out holds the write byte with ad_oe=1 for that whole time.
- R8: A cycle lasts 3 T-states for codes 1 to 4 and 4 T-states for an opcode fetch, plus one T-state for each wait state.
- R9: If READY is low at the clock edge that ends T2 or a wait state, another wait state follows with the strobes unchanged. T3 follows the first edge at which READY is high.
- R10: The byte on ad_in is registered at the edge that ends T3 and shown on rdata. done is high for exactly the one clock after T3. This holds for every cycle kind.
- R11: The fourth T-state of an opcode fetch has ale=0, rd_n=1, addr_hi_oe=0 and ad_oe=0, so both address lanes are released.
- R12: rd_n and wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_code | input | 3 | Cycle kind, 0..4 |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| ready | input | 1 | High when the target can finish the cycle |
| ad_in | input | 8 | Byte read from the shared lane |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| addr_hi | output | 8 | Upper address byte |
| addr_hi_oe | output | 1 | Drive enable for addr_hi |
| ad_out | output | 8 | Low address byte or write byte |
| ad_oe | output | 1 | Drive enable for the shared lane |
| rdata | output | 8 | Byte captured at the end of T3 |
| done | output | 1 | One-clock completion pulse |

## Verification
Each of the five cycle kinds runs with READY held high. This separates the four-state fetch from the three-state cycles and shows that the status and select encodings differ by kind. The same kinds then run with one to three wait states, which checks that the strobes stretch and that the capture point and the done pulse move with them. Requests made mid-cycle and requests with codes 5 and 7 must produce no extra ale pulse. Distinct read bytes and write bytes per cycle confirm that data comes from the current cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   typedef enum logic [2:0] {
      CYC_FETCH = 3'd0,
      CYC_MRD   = 3'd1,
      CYC_MWR   = 3'd2,
      CYC_IORD  = 3'd3,
      CYC_IOWR  = 3'd4
   } cyc_e;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_T1,
      TS_T2,
      TS_TW,
      TS_T3,
      TS_T4
   } tstate_e;

   typedef struct packed {
      logic       valid;
      logic       is_read;
      logic       is_write;
      logic       io_sel;
      logic [1:0] status;
      logic       has_t4;
   } cyc_attr_t;

endpackage

// File: rtl/mbus_cyc_decode.sv
module mbus_cyc_decode
   import mbus_pkg::*;
(
   input  logic [2:0] code,
   output cyc_attr_t  attr
);

   always_comb begin
      attr = '0;
      case (code)
         CYC_FETCH: attr = '{valid: 1'b1, is_read: 1'b1, is_write: 1'b0, io_sel: 1'b0, status: 2'b11, has_t4: 1'b1};
         CYC_MRD:   attr = '{valid: 1'b1, is_read: 1'b1, is_write: 1'b0, io_sel: 1'b0, status: 2'b10, has_t4: 1'b0};
         CYC_MWR:   attr = '{valid: 1'b1, is_read: 1'b0, is_write: 1'b1, io_sel: 1'b0, status: 2'b01, has_t4: 1'b0};
         CYC_IORD:  attr = '{valid: 1'b1, is_read: 1'b1, is_write: 1'b0, io_sel: 1'b1, status: 2'b10, has_t4: 1'b0};
         CYC_IOWR:  attr = '{valid: 1'b1, is_read: 1'b0, is_write: 1'b1, io_sel: 1'b1, status: 2'b01, has_t4: 1'b0};
         default:   attr = '0;
      endcase
   end

endmodule

// File: rtl/mbus_tstate_fsm.sv
module mbus_tstate_fsm
   import mbus_pkg::*;
#(
   parameter bit WAIT_EN = 1'b1
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    has_t4,
   input  logic    ready,
   output tstate_e state,
   output logic    cap_en,
   output logic    done
);

   logic    rdy_eff;
   tstate_e nxt;

   generate
      if (WAIT_EN) begin : g_wait
         assign rdy_eff = ready;
      end else begin : g_nowait
         assign rdy_eff = 1'b1;
      end
   endgenerate

   always_comb begin
      nxt = state;
      case (state)
         TS_IDLE: if (start) nxt = TS_T1;
         TS_T1:   nxt = TS_T2;
         TS_T2:   nxt = rdy_eff ? TS_T3 : TS_TW;
         TS_TW:   nxt = rdy_eff ? TS_T3 : TS_TW;
         TS_T3:   nxt = has_t4 ? TS_T4 : TS_IDLE;
         TS_T4:   nxt = TS_IDLE;
         default: nxt = TS_IDLE;
      endcase
   end

   assign cap_en = (state == TS_T3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TS_IDLE;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= cap_en;
      end
   end

   // R9
   wait_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == TS_T2 || state == TS_TW) && !rdy_eff) |=> state == TS_TW);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   fetch_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_T3 && has_t4) |=> state == TS_T4);

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  tstate_e                  state,
   input  cyc_attr_t                attr,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     cap_en,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   output logic [1:0]               status,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic                     addr_hi_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [DATA_W-1:0]        rdata
);

   logic active, strobe_ph;

   assign active     = (state != TS_IDLE);
   assign strobe_ph  = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
   assign ale        = (state == TS_T1);
   assign status     = active ? attr.status : 2'b00;
   assign io_m       = active & attr.io_sel;
   assign rd_n       = ~(strobe_ph & attr.is_read);
   assign wr_n       = ~(strobe_ph & attr.is_write);
   assign addr_hi    = addr[ADDR_W-1:DATA_W];
   assign addr_hi_oe = ale | strobe_ph;
   assign ad_oe      = ale | (strobe_ph & attr.is_write);
   assign ad_out     = ale ? addr[DATA_W-1:0] : wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (cap_en) rdata <= ad_in;
   end

   // R12
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R6
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R7
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> ($stable(ad_out) && ad_oe));

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter bit WAIT_EN = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [2:0]               req_code,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     ready,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   output logic                     s1,
   output logic                     s0,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic                     addr_hi_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [DATA_W-1:0]        rdata,
   output logic                     done
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("ADDR_W must exceed DATA_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   cyc_attr_t         dec_attr, cur_attr;
   tstate_e           state;
   logic              start, cap_en;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic [1:0]        status;

   mbus_cyc_decode u_dec (
      .code (req_code),
      .attr (dec_attr)
   );

   assign start = req_valid && dec_attr.valid && (state == TS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_attr  <= '0;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else if (start) begin
         cur_attr  <= dec_attr;
         cur_addr  <= req_addr;
         cur_wdata <= req_wdata;
      end
   end

   mbus_tstate_fsm #(.WAIT_EN(WAIT_EN)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .has_t4 (cur_attr.has_t4),
      .ready  (ready),
      .state  (state),
      .cap_en (cap_en),
      .done   (done)
   );

   mbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .attr       (cur_attr),
      .addr       (cur_addr),
      .wdata      (cur_wdata),
      .cap_en     (cap_en),
      .ad_in      (ad_in),
      .ale        (ale),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .io_m       (io_m),
      .status     (status),
      .addr_hi    (addr_hi),
      .addr_hi_oe (addr_hi_oe),
      .ad_out     (ad_out),
      .ad_oe      (ad_oe),
      .rdata      (rdata)
   );

   assign s1 = status[1];
   assign s0 = status[0];

   // R3
   ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R2
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != TS_IDLE && state != TS_T3 && state != TS_T4) |=> !ale);

   // R4
   status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_IDLE) |-> ({s1, s0} == 2'b00 && !io_m));

endmodule

// File: tb/mbus_cycle_seq_tb.sv
module mbus_cycle_seq_tb;

   typedef struct {
      logic [2:0]  code;
      logic [15:0] addr;
      logic [7:0]  wd;
      logic [7:0]  rd;
      int          waits;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_code = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        ready = 1'b1;
   logic [7:0]  ad_in = 8'h0;
   logic        ale, rd_n, wr_n, io_m, s1, s0, addr_hi_oe, ad_oe, done;
   logic [7:0]  addr_hi, ad_out, rdata;

   int    checks = 0;
   int    errors = 0;
   int    n_ale = 0;
   int    n_issued = 0;
   int    cycles = 0;
   item_t q[$];
   item_t cur;
   bit    active = 0;
   int    len = 0;

   always #10 clk = ~clk;

   mbus_cycle_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
      .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
      .rdata(rdata), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit is_rd(input logic [2:0] c);
      return c == 3'd0 || c == 3'd1 || c == 3'd3;
   endfunction
   function automatic bit is_wr(input logic [2:0] c);
      return c == 3'd2 || c == 3'd4;
   endfunction
   function automatic logic [1:0] exp_st(input logic [2:0] c);
      return (c == 3'd0) ? 2'b11 : is_rd(c) ? 2'b10 : 2'b01;
   endfunction
   function automatic int exp_len(input item_t it);
      return ((it.code == 3'd0) ? 4 : 3) + it.waits;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && active && is_rd(cur.code))
            chk(rdata == cur.rd, "R10", "read byte", rdata, cur.rd);
         chk(!(!rd_n && !wr_n), "R12", "strobe overlap", {rd_n, wr_n}, 2'b11);
         if (ale) begin
            n_ale++;
            if (active) chk(len == exp_len(cur), "R8", "cycle length", len, exp_len(cur));
            if (q.size() == 0) begin
               chk(0, "R2", "unexpected ale", 1, 0);
               active = 0;
            end else begin
               cur = q.pop_front();
               active = 1;
               len = 1;
               chk({s1, s0} == exp_st(cur.code), "R4", "status T1", {s1, s0}, exp_st(cur.code));
               chk(io_m == (cur.code >= 3'd3), "R5", "io_m", io_m, cur.code >= 3'd3);
               chk(ad_oe && ad_out == cur.addr[7:0], "R3", "low addr", ad_out, cur.addr[7:0]);
               chk(addr_hi_oe && addr_hi == cur.addr[15:8], "R3", "high addr", addr_hi, cur.addr[15:8]);
            end
         end else if (active && {s1, s0} != 2'b00) begin
            len++;
            chk({s1, s0} == exp_st(cur.code), "R4", "status held", {s1, s0}, exp_st(cur.code));
            chk(rd_n == !(is_rd(cur.code) && len >= 2 && len <= 3 + cur.waits),
                "R6", "rd_n", rd_n, !(is_rd(cur.code) && len >= 2 && len <= 3 + cur.waits));
            chk(wr_n == !(is_wr(cur.code) && len >= 2 && len <= 3 + cur.waits),
                "R7", "wr_n", wr_n, !(is_wr(cur.code) && len >= 2 && len <= 3 + cur.waits));
            if (is_wr(cur.code))
               chk(ad_oe && ad_out == cur.wd, "R7", "write byte", ad_out, cur.wd);
            else
               chk(!ad_oe, "R6", "lane released", ad_oe, 0);
            if (len == 4 + cur.waits)
               chk(!ale && rd_n && !addr_hi_oe && !ad_oe, "R11", "T4 release",
                   {ale, rd_n, addr_hi_oe, ad_oe}, 4'b0100);
            else
               chk(addr_hi_oe, "R3", "high addr held", addr_hi_oe, 1);
         end else if (active) begin
            chk(len == exp_len(cur), "R8", "cycle length", len, exp_len(cur));
            chk(!io_m, "R4", "idle select", io_m, 0);
            active = 0;
         end
      end
   end

   task automatic run(input logic [2:0] code, input logic [15:0] addr, input logic [7:0] wd,
                      input logic [7:0] rd, input int waits, input bit bump);
      item_t it;
      it.code = code; it.addr = addr; it.wd = wd; it.rd = rd; it.waits = waits;
      q.push_back(it);
      n_issued++;
      @(negedge clk);
      req_valid = 1'b1; req_code = code; req_addr = addr; req_wdata = wd;
      @(negedge clk);                       // T1
      req_valid = 1'b0; ad_in = rd;
      @(negedge clk);                       // T2
      ready = (waits == 0);
      if (bump) begin
         req_valid = 1'b1; req_code = 3'd1; req_addr = 16'hDEAD;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (waits > 0) begin
         repeat (waits - 1) @(negedge clk);
         ready = 1'b1;
      end
      while (!done) @(negedge clk);
      // R10: done lasts one clock
      @(negedge clk);
      chk(!done, "R10", "done width", done, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({ale, rd_n, wr_n, s1, s0, io_m, ad_oe, addr_hi_oe, done} == 9'b011000000,
          "R1", "reset outputs", {ale, rd_n, wr_n, s1, s0, io_m, ad_oe, addr_hi_oe, done}, 9'b011000000);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ale, rd_n, wr_n, s1, s0, done} == 6'b011000, "R1", "idle outputs",
          {ale, rd_n, wr_n, s1, s0, done}, 6'b011000);

      run(3'd0, 16'h2000, 8'h00, 8'h3E, 0, 0);
      run(3'd1, 16'h2001, 8'h00, 8'h32, 0, 0);
      run(3'd2, 16'h4050, 8'hA5, 8'h00, 0, 0);
      run(3'd3, 16'h0081, 8'h00, 8'h5C, 0, 0);
      run(3'd4, 16'h00F0, 8'h69, 8'h00, 0, 0);
      run(3'd0, 16'hC3A7, 8'h00, 8'h76, 2, 0);  // R9
      run(3'd1, 16'h1234, 8'h00, 8'hE1, 1, 1);  // R2, R9
      run(3'd2, 16'hFFFE, 8'h18, 8'h00, 3, 0);  // R9
      run(3'd4, 16'h0002, 8'h96, 8'h00, 1, 1);  // R2
      run(3'd3, 16'h8000, 8'h00, 8'h0F, 2, 0);

      // R2: codes outside 0..4 start nothing
      @(negedge clk);
      req_valid = 1'b1; req_code = 3'd5; req_addr = 16'h5555;
      @(negedge clk);
      req_code = 3'd7;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk({s1, s0} == 2'b00 && !ale, "R2", "invalid code idle", {s1, s0}, 0);
      chk(n_ale == n_issued, "R2", "ale count", n_ale, n_issued);
      chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule